// File: doc/BRIEF.md
# Serial Register Access Port

This block is a four-wire serial slave that lets a host reach a small bank of byte-wide registers. The host lowers the select line and sends a byte made of a fixed seven-bit device identifier and a direction bit. A write then sends a pointer byte and any number of data bytes. A read sends nothing more: it clocks out the register that the pointer already selects. The pointer byte also carries a mode flag. When the flag is set, the pointer steps to the next register after every byte, so one transaction can cover a run of registers.

All serial inputs are brought into the system clock through synchronizers and their edges are found by oversampling, so the serial clock has to be several times slower than the system clock. The lower registers can be written and drive a parallel control bus. The upper registers are read-only and show a parallel status bus. The serial output comes with a separate drive-enable, and a pad wrapper turns the pair into a tri-state pin.

Top module: `spi_reg_port`

## Requirements
- R1: The first byte of a transaction is the identifier 0010000 followed by a direction bit (0 = write, 1 = read). With any other identifier the rest of the transaction is ignored: no register or pointer changes, and the output enable stays low.
- R2: In a write, the second byte is the pointer byte: bit 7 is the step flag and bits 6:0 are the register address. Each later complete byte is stored into the register the pointer selects. Writable register i appears on ctrl_out[8i+7:8i].
- R3: With the step flag at 0, every data byte of a burst goes to the same register, so the last byte wins and the neighbouring registers are not touched.
- R4: With the step flag at 1, the pointer advances by one after each complete byte, and it wraps from address 127 to address 0.
- R5: The pointer and the step flag keep their values after the select line rises. A write that ends right after the pointer byte sets up a later read.
- R6: MOSI is sampled on rising SCK edges, MSB first. In a read, the MSB of the selected register is driven after the first falling SCK edge that follows the direction bit. Each later bit is driven after the next falling edge.
- R7: A read burst returns consecutive registers when the step flag is 1, and repeats the same register when it is 0.
- R8: miso_oe is low whenever the select line is high and for the whole of every write transaction. It is high only during the data phase of a read.
- R9: Addresses REG_COUNT-RO_COUNT to REG_COUNT-1 (12 to 15 by default) are read-only. Address RW_COUNT+k returns status_in[8k+7:8k], and writes to these addresses change nothing. Addresses REG_COUNT and above read as 0x00 and ignore writes.
- R10: Raising the select line in the middle of a byte ends the transaction. The partial byte changes neither a register nor the pointer.
- R11: After reset, every writable register is 0x00, the pointer is 0 with the step flag off, and miso_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the host |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial read data to the host |
| miso_oe | output | 1 | High while miso must be driven onto the pin |
| status_in | input | RO_COUNT*8 | Parallel values shown by the read-only registers |
| ctrl_out | output | RW_COUNT*8 | Contents of the writable registers |

## Verification
The storing of a data byte and the pointer step happen on the same clock edge. A stepping write burst must therefore use the address from before the step, while the pointer moves on. The bench provokes this with stepping bursts that cross from the writable range into the read-only range, and with bursts that wrap past address 127 to address 0. It judges the result in two ways: by watching the control bus, where a single byte must land in exactly one register, and by reading the same run back through the serial port, where a scoreboard compares each returned byte.

// File: rtl/spi_reg_port_pkg.sv
package spi_reg_port_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 7;

  typedef enum logic [2:0] {
    PH_ADDR,
    PH_PTR,
    PH_WRITE,
    PH_READ,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic cs_n_s,
  output logic mosi_s,
  output logic sck_rise,
  output logic sck_fall
);
  logic [STAGES-1:0] cs_p;
  logic [STAGES-1:0] sck_p;
  logic [STAGES-1:0] mosi_p;
  logic              sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p   <= '1;
      sck_p  <= '0;
      mosi_p <= '0;
      sck_d  <= 1'b0;
    end else begin
      cs_p   <= {cs_p[STAGES-2:0], cs_n};
      sck_p  <= {sck_p[STAGES-2:0], sck};
      mosi_p <= {mosi_p[STAGES-2:0], mosi};
      sck_d  <= sck_p[STAGES-1];
    end
  end

  assign cs_n_s   = cs_p[STAGES-1];
  assign mosi_s   = mosi_p[STAGES-1];
  assign sck_rise = sck_p[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_p[STAGES-1] & sck_d;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
  parameter int REG_COUNT = 16,
  parameter int RO_COUNT  = 4,
  localparam int RW_COUNT = REG_COUNT - RO_COUNT
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [6:0]            waddr,
  input  logic [7:0]            wdata,
  input  logic [6:0]            raddr,
  output logic [7:0]            rdata,
  input  logic [RO_COUNT*8-1:0] status_in,
  output logic [RW_COUNT*8-1:0] ctrl_out
);
  localparam logic [6:0] RW_LIM = 7'(RW_COUNT);

  generate
    for (genvar g = 0; g < RW_COUNT; g++) begin : g_rw
      logic [7:0] cell_q;
      always_ff @(posedge clk) begin
        if (rst) cell_q <= '0;
        else if (we && waddr == 7'(g)) cell_q <= wdata;
      end
      assign ctrl_out[g*8 +: 8] = cell_q;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < RW_COUNT; i++)
      if (raddr == 7'(i)) rdata = ctrl_out[i*8 +: 8];
    for (int k = 0; k < RO_COUNT; k++)
      if (raddr == 7'(RW_COUNT + k)) rdata = status_in[k*8 +: 8];
  end

  // R9
  ro_write_block_chk: assert property (@(posedge clk) disable iff (rst)
    (we && waddr >= RW_LIM) |=> $stable(ctrl_out));
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_reg_port_pkg::*;
#(
  parameter logic [6:0] CHIP_ID = 7'b0010000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n_s,
  input  logic       mosi_s,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic [7:0] rdata,
  output logic [6:0] ptr,
  output logic       we,
  output logic [6:0] waddr,
  output logic [7:0] wdata,
  output logic       miso,
  output logic       miso_oe
);
  phase_t     phase;
  logic [2:0] bit_cnt;
  logic [2:0] tx_cnt;
  logic [6:0] shreg;
  logic [7:0] sh_next;
  logic [7:0] tx;
  logic       inc;

  assign sh_next = {shreg, mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_ADDR;
      bit_cnt <= '0;
      tx_cnt  <= '0;
      shreg   <= '0;
      tx      <= '0;
      ptr     <= '0;
      inc     <= 1'b0;
      we      <= 1'b0;
      waddr   <= '0;
      wdata   <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      we <= 1'b0;
      if (cs_n_s) begin
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        tx_cnt  <= '0;
        miso    <= 1'b0;
        miso_oe <= 1'b0;
      end else begin
        if (sck_rise) begin
          shreg   <= sh_next[6:0];
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            case (phase)
              PH_ADDR: begin
                if (sh_next[7:1] != CHIP_ID) phase <= PH_SKIP;
                else if (sh_next[0])         phase <= PH_READ;
                else                         phase <= PH_PTR;
              end
              PH_PTR: begin
                ptr   <= sh_next[6:0];
                inc   <= sh_next[7];
                phase <= PH_WRITE;
              end
              PH_WRITE: begin
                we    <= 1'b1;
                waddr <= ptr;
                wdata <= sh_next;
                if (inc) ptr <= ptr + 7'd1;
              end
              PH_READ: begin
                if (inc) ptr <= ptr + 7'd1;
              end
              default: ;
            endcase
          end
        end
        if (sck_fall && phase == PH_READ) begin
          miso_oe <= 1'b1;
          if (tx_cnt == 3'd0) begin
            miso <= rdata[7];
            tx   <= {rdata[6:0], 1'b0};
          end else begin
            miso <= tx[7];
            tx   <= {tx[6:0], 1'b0};
          end
          tx_cnt <= tx_cnt + 3'd1;
        end
      end
    end
  end

  // R8
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !miso_oe);

  // R8
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> !miso_oe);

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WRITE && !inc) |=> $stable(ptr));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (we && inc) |-> (ptr == waddr + 7'd1));

  // R10
  frame_reset_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (bit_cnt == 3'd0 && phase == PH_ADDR));
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port #(
  parameter int         REG_COUNT   = 16,
  parameter int         RO_COUNT    = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] CHIP_ID     = 7'b0010000,
  localparam int        RW_COUNT    = REG_COUNT - RO_COUNT
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_n,
  input  logic                  sck,
  input  logic                  mosi,
  output logic                  miso,
  output logic                  miso_oe,
  input  logic [RO_COUNT*8-1:0] status_in,
  output logic [RW_COUNT*8-1:0] ctrl_out
);
  logic       cs_n_s, mosi_s, sck_rise, sck_fall;
  logic       we;
  logic [6:0] ptr, waddr;
  logic [7:0] wdata, rdata;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .cs_n_s(cs_n_s), .mosi_s(mosi_s), .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  spi_frame_engine #(.CHIP_ID(CHIP_ID)) u_engine (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .rdata(rdata),
    .ptr(ptr), .we(we), .waddr(waddr), .wdata(wdata),
    .miso(miso), .miso_oe(miso_oe)
  );

  spi_reg_bank #(.REG_COUNT(REG_COUNT), .RO_COUNT(RO_COUNT)) u_bank (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(ptr), .rdata(rdata), .status_in(status_in), .ctrl_out(ctrl_out)
  );
endmodule

// File: tb/sim_spi_reg_port.sv
module sim_spi_reg_port;
  localparam int HALF = 6;
  localparam logic [7:0] HDR_W = 8'h20;
  localparam logic [7:0] HDR_R = 8'h21;

  logic        clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic        miso, miso_oe;
  logic [31:0] status_in = 32'hD4C3B2A1;
  logic [95:0] ctrl_out;

  int checks = 0, failures = 0, oe_cycles = 0;
  logic [7:0] model [12];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;
  always @(posedge clk) if (miso_oe) oe_cycles++;

  spi_reg_port u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .status_in(status_in), .ctrl_out(ctrl_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_low();
    @(negedge clk) cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_high();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(3 * HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = b[i];
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic set_ptr(input logic [7:0] p);
    int oe0 = oe_cycles;
    cs_low(); send_bits(HDR_W, 8); send_bits(p, 8); cs_high();
    check("R8 oe during pointer write", oe_cycles, oe0);
  endtask

  task automatic write_burst(input logic [7:0] p, input int n,
                             input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    int oe0 = oe_cycles;
    cs_low(); send_bits(HDR_W, 8); send_bits(p, 8);
    if (n > 0) send_bits(d0, 8);
    if (n > 1) send_bits(d1, 8);
    if (n > 2) send_bits(d2, 8);
    cs_high();
    check("R8 oe during write", oe_cycles, oe0);
  endtask

  task automatic read_burst(input string tag, input int n,
                            input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2);
    if (n > 0) begin exp_q.push_back(e0); tag_q.push_back(tag); end
    if (n > 1) begin exp_q.push_back(e1); tag_q.push_back(tag); end
    if (n > 2) begin exp_q.push_back(e2); tag_q.push_back(tag); end
    cs_low(); send_bits(HDR_R, 8);
    for (int i = 0; i < n; i++) send_bits(8'h00, 8);
    cs_high();
    check({"R6 all read bytes seen: ", tag}, exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < 12; i++) check(req, ctrl_out[i*8 +: 8], model[i]);
  endtask

  // scoreboard monitor: rebuilds read bytes at host sampling edges
  initial begin
    int mcnt = 0;
    logic [7:0] mbyte = '0;
    forever begin
      @(posedge sck or posedge cs_n);
      if (cs_n) mcnt = 0;
      else if (miso_oe) begin
        mbyte = {mbyte[6:0], miso};
        mcnt++;
        if (mcnt == 8) begin
          mcnt = 0;
          if (exp_q.size() == 0) check("R1 unexpected read byte", mbyte, 32'hFFFF_FFFF);
          else check(tag_q.pop_front(), mbyte, exp_q.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    wait_clk(150000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int oe0;
    logic [95:0] snap;
    for (int i = 0; i < 12; i++) model[i] = 8'h00;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(4);
    // R11 reset state
    check_bank("R11 reset bank");
    check("R11 oe after reset", {31'd0, miso_oe}, 0);
    read_burst("R11 pointer 0 after reset", 1, 8'h00, 8'h00, 8'h00);

    // R2 single write
    write_burst(8'h02, 1, 8'hA5, 8'h00, 8'h00);
    model[2] = 8'hA5;
    check_bank("R2 single write");

    // R3 fixed pointer burst
    write_burst(8'h03, 3, 8'h11, 8'h22, 8'h33);
    model[3] = 8'h33;
    check_bank("R3 fixed burst");

    // R4 stepping burst
    write_burst(8'h85, 3, 8'h51, 8'h62, 8'h73);
    model[5] = 8'h51; model[6] = 8'h62; model[7] = 8'h73;
    check_bank("R4 stepping burst");

    // R5 R7 stepping read after partial write
    set_ptr(8'h85);
    read_burst("R5 R7 stepping read", 3, 8'h51, 8'h62, 8'h73);

    // R7 fixed read repeats
    set_ptr(8'h02);
    read_burst("R7 fixed read", 2, 8'hA5, 8'hA5, 8'h00);

    // R9 burst crossing into read-only range
    write_burst(8'h8B, 3, 8'h99, 8'hEE, 8'hEE);
    model[11] = 8'h99;
    check_bank("R9 read-only writes");
    set_ptr(8'h8B);
    read_burst("R9 status readback", 3, 8'h99, 8'hA1, 8'hB2);

    // R4 wrap and R9 out-of-range address
    write_burst(8'hFF, 2, 8'h01, 8'h3C, 8'h00);
    model[0] = 8'h3C;
    check_bank("R4 wrap write");
    set_ptr(8'hFF);
    read_burst("R4 R9 wrap read", 2, 8'h00, 8'h3C, 8'h00);

    // R1 wrong identifier, write and read
    snap = ctrl_out;
    cs_low(); send_bits(8'h42, 8); send_bits(8'h01, 8); send_bits(8'h77, 8); cs_high();
    check("R1 ignored write", ctrl_out, snap);
    oe0 = oe_cycles;
    cs_low(); send_bits(8'h43, 8); send_bits(8'h00, 8); cs_high();
    check("R1 ignored read oe", oe_cycles, oe0);

    // R10 abort mid data byte and mid pointer byte
    cs_low(); send_bits(HDR_W, 8); send_bits(8'h07, 8); send_bits(8'hFF, 4); cs_high();
    check_bank("R10 partial data byte");
    cs_low(); send_bits(HDR_W, 8); send_bits(8'h02, 5); cs_high();
    read_burst("R10 pointer kept after partial byte", 1, 8'h73, 8'h00, 8'h00);
    check("R8 oe low after read", {31'd0, miso_oe}, 0);

    finish_run();
  end
endmodule